// File: doc/BRIEF.md
# Control Endpoint Phase and Handshake Controller

This block runs endpoint zero of a USB device. It sits between a simplified packet interface and a firmware-facing control/status register. Line coding, CRC and PID checks happen upstream. The packet side reports three things: token arrivals, data bytes, and an end-of-packet strobe. The end-of-packet strobe carries the data PID and a corruption flag. The block follows each control transfer through its setup, data and status phases. It loads received bytes into a small FIFO and keeps a count of the bytes held there. It answers each token or data packet with ACK, NAK or STALL. It also tells the transmitter when to send the bytes that firmware has queued.

Firmware works through a six-bit status register. Writing the same register sets or clears the handshake bits. A single interrupt pulse marks every qualifying event: a packet loaded, an IN packet acknowledged, a status stage finished, a STALL sent, or a transfer ended early. A sticky pending bit records the interrupt, and firmware clears it by reading it.

Top module: `ep0_ctrl`

## Requirements
- R1: A SETUP data packet of exactly 8 bytes is loaded, answered with ACK (hs_code 0), sets out-ready (status bit 0) and raises irq, and byte_cnt reads 8. A SETUP packet of any other length is discarded without a handshake and byte_cnt stays 0. Bit 7 of its first byte picks the direction: 1 means device-to-host data.
- R2: A data packet flagged as corrupted at end of packet causes no handshake, no interrupt, and no change to out-ready or byte_cnt.
- R3: In a host-to-device data phase, an OUT packet is loaded and ACKed when out-ready is clear. When out-ready is set, the packet is NAKed (hs_code 1) and byte_cnt keeps its value. A firmware read pops the head byte and lowers byte_cnt by one. Writing 1 to write-bit 0 clears out-ready and empties the FIFO.
- R4: In a device-to-host data phase with in-ready (bit 1) set, an IN token pulses tx_start, and tx_len equals byte_cnt. The host acknowledgement that follows clears in-ready, empties the FIFO and raises irq.
- R5: Status stages complete in two ways, and each raises irq and clears data-end (bit 3). After a host-to-device transfer, the stage is a zero-length transmit (tx_start, tx_len 0) followed by a host acknowledgement. After a device-to-host transfer, it is a zero-length OUT packet answered with ACK.
- R6: An OUT token in a host-to-device data phase after data-end is set is answered with STALL (hs_code 2).
- R7: An IN token in a device-to-host data phase with data-end set and in-ready clear is answered with STALL.
- R8: A data packet longer than MAX_PKT bytes is answered with STALL, and none of its bytes remain in the FIFO.
- R9: In the status stage of a device-to-host transfer, a DATA1 packet with one or more bytes is answered with STALL.
- R10: Writing 1 to bit 5 sets send-stall and abandons the transfer. The next IN or OUT token gets STALL, and send-stall then reads 0.
- R11: Every STALL sets sent-stall (bit 2) and raises irq. Writing 1 to bit 2 clears it.
- R12: If the host moves to the status direction before data-end is set, or starts a new SETUP, setup-end (bit 4) is set and irq is raised. Writing 1 to bit 4 clears it.
- R13: irq is high for exactly one cycle per event. irq_pend stays set until an irq_rd strobe clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tok_valid | input | 1 | Token strobe |
| tok_kind | input | 2 | Token: 0 OUT, 1 IN, 2 SETUP |
| rx_bvalid | input | 1 | Received data byte strobe |
| rx_bdata | input | 8 | Received data byte |
| rx_eop | input | 1 | End of received data packet |
| rx_pid1 | input | 1 | Packet was DATA1 (valid with rx_eop) |
| rx_err | input | 1 | Packet was corrupted (valid with rx_eop) |
| host_ack | input | 1 | Host ACK for a transmitted packet |
| hs_valid | output | 1 | Handshake response strobe |
| hs_code | output | 2 | 0 ACK, 1 NAK, 2 STALL |
| tx_start | output | 1 | Start transmitting a data packet |
| tx_len | output | clog2(DEPTH)+1 | Bytes to transmit |
| tx_rd | input | 1 | Transmitter pops one FIFO byte |
| fifo_rdata | output | 8 | FIFO head byte |
| fw_wr | input | 1 | Firmware pushes one byte for IN |
| fw_wdata | input | 8 | Firmware byte |
| fw_rd | input | 1 | Firmware pops one FIFO byte |
| csr_wr | input | 1 | Control write strobe |
| csr_wdata | input | 6 | Write bits: 0 service out-ready, 1 set in-ready, 2 clear sent-stall, 3 set data-end, 4 clear setup-end, 5 send stall |
| csr_rdata | output | 6 | Status: 0 out-ready, 1 in-ready, 2 sent-stall, 3 data-end, 4 setup-end, 5 send-stall |
| byte_cnt | output | clog2(DEPTH)+1 | Bytes held in the FIFO |
| irq | output | 1 | One-cycle interrupt pulse |
| irq_pend | output | 1 | Sticky interrupt status |
| irq_rd | input | 1 | Read-and-clear of irq_pend |

## Verification
The bench builds the block with DEPTH and MAX_PKT both set to 16. An oversize packet then needs only 17 bytes. This lets the bench drive the FIFO's full limit and the rollback after a STALL cheaply, while the 8-byte SETUP still fits with room to spare. With these values, every stall rule, both status-stage forms and the early-end case are reached in a few hundred cycles.

// File: rtl/ep0_pkg.sv
// Shared encodings for the endpoint-zero controller.
// Assumes: token, handshake and register bit positions are fixed by the port contract.
package ep0_pkg;
    typedef enum logic [1:0] {TOK_OUT = 2'd0, TOK_IN = 2'd1, TOK_SETUP = 2'd2} tok_e;
    typedef enum logic [1:0] {HS_ACK = 2'd0, HS_NAK = 2'd1, HS_STALL = 2'd2} hs_e;
    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_OUT, PH_IN} phase_e;
    typedef enum logic [1:0] {EX_NONE, EX_SETUP, EX_OUT, EX_STAT} expect_e;
    typedef enum logic [1:0] {WA_NONE, WA_DATA, WA_STAT} wait_e;

    localparam int CSR_W      = 6;
    localparam int SETUP_LEN  = 8;
    // status/write bit positions
    localparam int B_OUT_RDY  = 0;
    localparam int B_IN_RDY   = 1;
    localparam int B_STALLED  = 2;
    localparam int B_DATA_END = 3;
    localparam int B_EARLY    = 4;
    localparam int B_FORCE    = 5;
endpackage

// File: rtl/ep0_fifo.sv
// Byte FIFO with a tentative write pointer.
// Received bytes land beyond the committed pointer and become visible only on commit;
// abort rolls them back. flush empties everything.
// Assumes: DEPTH is a power of two.
module ep0_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     wr_en,
    input  logic [W-1:0]             wr_data,
    input  logic                     commit,
    input  logic                     abort,
    input  logic                     rd_en,
    output logic [W-1:0]             rd_data,
    output logic [$clog2(DEPTH):0]   count
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, cm_ptr, rd_ptr, wr_next;
    logic          wr_ok;

    assign wr_ok   = wr_en && ((wr_ptr - rd_ptr) < PW'(DEPTH));
    assign wr_next = wr_ok ? wr_ptr + 1'b1 : wr_ptr;
    assign rd_data = mem[rd_ptr[AW-1:0]];
    assign count   = cm_ptr - rd_ptr;

    // Storage write at the tentative pointer.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr[AW-1:0]] <= wr_data;
    end

    // Pointer bookkeeping: flush, rollback, commit and pop.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            cm_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (abort) wr_ptr <= cm_ptr;
            else       wr_ptr <= wr_next;
            if (commit) cm_ptr <= wr_next;
            if (rd_en && (cm_ptr != rd_ptr)) rd_ptr <= rd_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/ep0_phase.sv
// Control-transfer phase tracker: decides handshakes, stall rules, early-end detection,
// FIFO commit/rollback and the interrupt event for each token or packet.
// Assumes: token, end-of-packet and host_ack never share a cycle; the last data byte
// strobe comes at least one cycle before rx_eop; fw_wr never coincides with rx_bvalid.
module ep0_phase
    import ep0_pkg::*;
#(
    parameter int MAX_PKT = 64,
    parameter int CW      = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  logic [1:0]        tok_kind,
    input  logic              rx_bvalid,
    input  logic [7:0]        rx_bdata,
    input  logic              rx_eop,
    input  logic              rx_pid1,
    input  logic              rx_err,
    input  logic              host_ack,
    input  logic              csr_wr,
    input  logic [CSR_W-1:0]  csr_wdata,
    input  logic [CW-1:0]     count,
    output logic              hs_valid,
    output logic [1:0]        hs_code,
    output logic              tx_start,
    output logic [CW-1:0]     tx_len,
    output logic              f_wr,
    output logic              f_commit,
    output logic              f_abort,
    output logic              f_flush,
    output logic              ev,
    output logic [CSR_W-1:0]  status
);
    localparam int LW = $clog2(MAX_PKT + 2);

    phase_e  phase, ph_n;
    expect_e expct, ex_n;
    wait_e   waitq, wa_n;
    tok_e    tok;
    logic [LW-1:0] rx_len;
    logic out_rdy, in_rdy, data_end, stalled, early, force_stall, dir_in;
    logic a_stall, a_ack, a_nak, a_send, a_early, a_ev;
    logic go_commit, go_abort, go_flush, set_out, clr_in, clr_dend;
    logic [CW-1:0] send_len;

    assign tok    = tok_e'(tok_kind);
    assign status = {force_stall, early, data_end, stalled, in_rdy, out_rdy};
    assign f_wr   = rx_bvalid && (expct == EX_SETUP || (expct == EX_OUT && !out_rdy));
    assign f_commit = go_commit;
    assign f_abort  = go_abort;
    assign f_flush  = go_flush || (csr_wr && csr_wdata[B_OUT_RDY]);
    assign ev       = a_ev || a_stall || a_early || set_out;

    // Decide the response to this cycle's token, packet end or host acknowledgement.
    always_comb begin
        a_stall = 1'b0; a_ack = 1'b0; a_nak = 1'b0; a_send = 1'b0; a_early = 1'b0;
        a_ev = 1'b0; go_commit = 1'b0; go_abort = 1'b0; go_flush = 1'b0;
        set_out = 1'b0; clr_in = 1'b0; clr_dend = 1'b0; send_len = '0;
        ph_n = phase; ex_n = expct; wa_n = waitq;
        if (tok_valid) begin
            ex_n = EX_NONE;
            wa_n = WA_NONE;
            go_abort = 1'b1;
            unique case (tok)
                TOK_SETUP: begin
                    a_early  = (phase == PH_OUT || phase == PH_IN) && !data_end;
                    go_flush = 1'b1;
                    ph_n     = PH_SETUP;
                    ex_n     = EX_SETUP;
                end
                TOK_OUT: begin
                    if (force_stall || phase == PH_IDLE || phase == PH_SETUP) a_stall = 1'b1;
                    else if (phase == PH_OUT) begin
                        if (data_end) a_stall = 1'b1;
                        else          ex_n = EX_OUT;
                    end else if (data_end) ex_n = EX_STAT;
                    else begin
                        a_early = 1'b1;
                        a_nak   = 1'b1;
                        ph_n    = PH_IDLE;
                    end
                end
                TOK_IN: begin
                    if (force_stall || phase == PH_IDLE || phase == PH_SETUP) a_stall = 1'b1;
                    else if (phase == PH_IN) begin
                        if (in_rdy) begin
                            a_send   = 1'b1;
                            send_len = count;
                            wa_n     = WA_DATA;
                        end else if (data_end) a_stall = 1'b1;
                        else                   a_nak = 1'b1;
                    end else if (data_end) begin
                        a_send = 1'b1;
                        wa_n   = WA_STAT;
                    end else begin
                        a_early = 1'b1;
                        a_nak   = 1'b1;
                        ph_n    = PH_IDLE;
                    end
                end
                default: begin
                    ex_n = expct;
                    wa_n = waitq;
                    go_abort = 1'b0;
                end
            endcase
        end else if (rx_eop) begin
            ex_n = EX_NONE;
            if (rx_err || expct == EX_NONE) go_abort = 1'b1;
            else if (expct == EX_SETUP) begin
                if (rx_len == LW'(SETUP_LEN)) begin
                    go_commit = 1'b1;
                    set_out   = 1'b1;
                    a_ack     = 1'b1;
                    ph_n      = dir_in ? PH_IN : PH_OUT;
                end else begin
                    go_abort = 1'b1;
                    ph_n     = PH_IDLE;
                end
            end else if (rx_len > LW'(MAX_PKT)) a_stall = 1'b1;
            else if (expct == EX_OUT) begin
                if (out_rdy) begin
                    go_abort = 1'b1;
                    a_nak    = 1'b1;
                end else begin
                    go_commit = 1'b1;
                    set_out   = 1'b1;
                    a_ack     = 1'b1;
                end
            end else if (rx_len == '0) begin
                a_ack    = 1'b1;
                a_ev     = 1'b1;
                clr_dend = 1'b1;
                ph_n     = PH_IDLE;
            end else if (rx_pid1) a_stall = 1'b1;
            else                  a_nak = 1'b1;
        end else if (host_ack) begin
            wa_n = WA_NONE;
            if (waitq == WA_DATA) begin
                clr_in   = 1'b1;
                go_flush = 1'b1;
                a_ev     = 1'b1;
            end else if (waitq == WA_STAT) begin
                a_ev     = 1'b1;
                clr_dend = 1'b1;
                ph_n     = PH_IDLE;
            end
        end
        if (a_stall) begin
            ph_n = PH_IDLE;
            ex_n = EX_NONE;
            wa_n = WA_NONE;
            go_abort = 1'b1;
        end
    end

    // Register phase state, flags, responses and firmware writes (writes take effect last).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE; expct <= EX_NONE; waitq <= WA_NONE;
            rx_len <= '0; dir_in <= 1'b0;
            out_rdy <= 1'b0; in_rdy <= 1'b0; data_end <= 1'b0;
            stalled <= 1'b0; early <= 1'b0; force_stall <= 1'b0;
            hs_valid <= 1'b0; hs_code <= HS_ACK; tx_start <= 1'b0; tx_len <= '0;
        end else begin
            phase <= ph_n; expct <= ex_n; waitq <= wa_n;
            hs_valid <= a_ack || a_nak || a_stall;
            hs_code  <= a_stall ? HS_STALL : (a_nak ? HS_NAK : HS_ACK);
            tx_start <= a_send;
            tx_len   <= send_len;
            if (tok_valid) rx_len <= '0;
            else if (rx_bvalid && rx_len != '1) rx_len <= rx_len + 1'b1;
            if (rx_bvalid && expct == EX_SETUP && rx_len == '0) dir_in <= rx_bdata[7];
            if (tok_valid && tok == TOK_SETUP) begin
                out_rdy <= 1'b0; in_rdy <= 1'b0; data_end <= 1'b0;
            end
            if (set_out)  out_rdy  <= 1'b1;
            if (clr_in)   in_rdy   <= 1'b0;
            if (clr_dend) data_end <= 1'b0;
            if (a_early)  early    <= 1'b1;
            if (a_stall) begin
                stalled <= 1'b1; force_stall <= 1'b0; data_end <= 1'b0; in_rdy <= 1'b0;
            end
            if (csr_wr) begin
                if (csr_wdata[B_OUT_RDY])  out_rdy  <= 1'b0;
                if (csr_wdata[B_IN_RDY])   in_rdy   <= 1'b1;
                if (csr_wdata[B_STALLED])  stalled  <= 1'b0;
                if (csr_wdata[B_DATA_END]) data_end <= 1'b1;
                if (csr_wdata[B_EARLY])    early    <= 1'b0;
                if (csr_wdata[B_FORCE]) begin
                    force_stall <= 1'b1;
                    phase <= PH_IDLE; expct <= EX_NONE; waitq <= WA_NONE;
                end
            end
        end
    end
endmodule

// File: rtl/ep0_irq.sv
// Interrupt output stage: one-cycle pulse per event plus a sticky pending bit
// that a read strobe clears; a new event in the read cycle keeps it set.
module ep0_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic ev,
    input  logic rd,
    output logic irq,
    output logic pend
);
    // Pulse and sticky status, both updated at the event edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq  <= 1'b0;
            pend <= 1'b0;
        end else begin
            irq  <= ev;
            pend <= ev || (pend && !rd);
        end
    end
endmodule

// File: rtl/ep0_ctrl.sv
// Endpoint-zero control handshake controller (top).
// Joins the phase tracker, the shared byte FIFO and the interrupt stage.
// Assumes: DEPTH is a power of two, DEPTH >= MAX_PKT >= 8.
module ep0_ctrl #(
    parameter int DEPTH   = 64,
    parameter int MAX_PKT = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tok_valid,
    input  logic [1:0]              tok_kind,
    input  logic                    rx_bvalid,
    input  logic [7:0]              rx_bdata,
    input  logic                    rx_eop,
    input  logic                    rx_pid1,
    input  logic                    rx_err,
    input  logic                    host_ack,
    output logic                    hs_valid,
    output logic [1:0]              hs_code,
    output logic                    tx_start,
    output logic [$clog2(DEPTH):0]  tx_len,
    input  logic                    tx_rd,
    output logic [7:0]              fifo_rdata,
    input  logic                    fw_wr,
    input  logic [7:0]              fw_wdata,
    input  logic                    fw_rd,
    input  logic                    csr_wr,
    input  logic [5:0]              csr_wdata,
    output logic [5:0]              csr_rdata,
    output logic [$clog2(DEPTH):0]  byte_cnt,
    output logic                    irq,
    output logic                    irq_pend,
    input  logic                    irq_rd
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic f_wr, f_commit, f_abort, f_flush, ev;

    ep0_phase #(.MAX_PKT(MAX_PKT), .CW(CW)) u_phase (
        .clk(clk), .rst_n(rst_n),
        .tok_valid(tok_valid), .tok_kind(tok_kind),
        .rx_bvalid(rx_bvalid), .rx_bdata(rx_bdata),
        .rx_eop(rx_eop), .rx_pid1(rx_pid1), .rx_err(rx_err),
        .host_ack(host_ack), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .count(byte_cnt),
        .hs_valid(hs_valid), .hs_code(hs_code),
        .tx_start(tx_start), .tx_len(tx_len),
        .f_wr(f_wr), .f_commit(f_commit), .f_abort(f_abort), .f_flush(f_flush),
        .ev(ev), .status(csr_rdata)
    );

    ep0_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .flush(f_flush),
        .wr_en(f_wr || fw_wr),
        .wr_data(f_wr ? rx_bdata : fw_wdata),
        .commit(f_commit || fw_wr),
        .abort(f_abort),
        .rd_en(fw_rd || tx_rd),
        .rd_data(fifo_rdata),
        .count(byte_cnt)
    );

    ep0_irq u_irq (
        .clk(clk), .rst_n(rst_n), .ev(ev), .rd(irq_rd),
        .irq(irq), .pend(irq_pend)
    );
endmodule

// File: rtl/ep0_ctrl_chk.sv
// Checker for ep0_ctrl: relates status, handshake and interrupt ports over time.
module ep0_ctrl_chk #(
    parameter int DEPTH = 64
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   hs_valid,
    input logic [1:0]             hs_code,
    input logic                   tx_start,
    input logic                   csr_wr,
    input logic [5:0]             csr_wdata,
    input logic [5:0]             csr_rdata,
    input logic [$clog2(DEPTH):0] byte_cnt,
    input logic                   irq,
    input logic                   irq_pend
);
    // R1
    out_ready_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csr_rdata[0]) |-> irq);
    // R11
    stall_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_code == 2'd2 && !$past(csr_wr && csr_wdata[2])) |-> (csr_rdata[2] && irq));
    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(byte_cnt) <= DEPTH);
    // R13
    irq_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_pend);
    // R4
    single_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> !hs_valid);
    // R12
    early_end_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csr_rdata[4]) |-> irq);
endmodule

bind ep0_ctrl ep0_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .hs_valid(hs_valid), .hs_code(hs_code),
    .tx_start(tx_start), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .byte_cnt(byte_cnt), .irq(irq), .irq_pend(irq_pend)
);

// File: tb/tb_ep0_ctrl.sv
// Directed bench for ep0_ctrl: one task per scenario, each checking its own results.
module tb_ep0_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH   = 16;
    localparam int MAX_PKT = 16;
    localparam int CW = $clog2(DEPTH) + 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tok_valid = 0, rx_bvalid = 0, rx_eop = 0, rx_pid1 = 0, rx_err = 0, host_ack = 0;
    logic [1:0] tok_kind = 0;
    logic [7:0] rx_bdata = 0, fw_wdata = 0;
    logic tx_rd = 0, fw_wr = 0, fw_rd = 0, csr_wr = 0, irq_rd = 0;
    logic [5:0] csr_wdata = 0;
    logic hs_valid, tx_start, irq, irq_pend;
    logic [1:0] hs_code;
    logic [CW-1:0] tx_len, byte_cnt;
    logic [7:0] fifo_rdata;
    logic [5:0] csr_rdata;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    logic c_hsv, c_irq, c_tx;
    logic [1:0] c_hs;
    int c_len;

    ep0_ctrl #(.DEPTH(DEPTH), .MAX_PKT(MAX_PKT)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(bit ok, string tag, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic capture();
        c_hsv = hs_valid; c_hs = hs_code; c_irq = irq; c_tx = tx_start; c_len = int'(tx_len);
    endtask

    task automatic token(int k);
        @(negedge clk); tok_valid = 1; tok_kind = 2'(k);
        @(negedge clk); capture(); tok_valid = 0;
    endtask

    task automatic bytes(int n, int b0);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rx_bvalid = 1; rx_bdata = 8'(b0 + i);
        end
        @(negedge clk); rx_bvalid = 0;
    endtask

    task automatic eop(bit pid1, bit err);
        @(negedge clk); rx_eop = 1; rx_pid1 = pid1; rx_err = err;
        @(negedge clk); capture(); rx_eop = 0; rx_err = 0; rx_pid1 = 0;
    endtask

    task automatic csr(int v);
        @(negedge clk); csr_wr = 1; csr_wdata = 6'(v);
        @(negedge clk); capture(); csr_wr = 0; csr_wdata = 0;
    endtask

    task automatic hack();
        @(negedge clk); host_ack = 1;
        @(negedge clk); capture(); host_ack = 0;
    endtask

    task automatic pop_fw();
        @(negedge clk); fw_rd = 1;
        @(negedge clk); fw_rd = 0;
    endtask

    task automatic push_fw(int v);
        @(negedge clk); fw_wr = 1; fw_wdata = 8'(v);
        @(negedge clk); fw_wr = 0;
    endtask

    // Accepted SETUP, then serviced; dir selects first byte bit 7.
    task automatic setup_ok(bit dir, string tag);
        token(2); bytes(8, dir ? 8'h80 : 8'h00); eop(0, 0);
        chk(c_hsv && c_hs == 0, {tag, " setup ACK"}, c_hs, 0);
        csr(1);
    endtask

    task automatic t_reset();
        chk(csr_rdata == 0, "R13 reset status", csr_rdata, 0);
        chk(byte_cnt == 0 && !irq && !irq_pend, "R13 reset count/irq", byte_cnt, 0);
    endtask

    task automatic t_setup();
        token(2); bytes(8, 8'h21); eop(0, 0);
        chk(c_hsv && c_hs == 0 && c_irq, "R1 setup ack+irq", c_hs, 0);
        chk(csr_rdata[0] == 1, "R1 out-ready", csr_rdata[0], 1);
        chk(byte_cnt == 8, "R1 count 8", byte_cnt, 8);
        chk(fifo_rdata == 8'h21, "R3 head byte", fifo_rdata, 8'h21);
        pop_fw();
        chk(byte_cnt == 7 && fifo_rdata == 8'h22, "R3 pop", byte_cnt, 7);
        csr(1);
        chk(csr_rdata[0] == 0 && byte_cnt == 0, "R3 service", byte_cnt, 0);
        token(2); bytes(7, 1); eop(0, 0);
        chk(!c_hsv && !c_irq, "R1 short setup no handshake", c_hsv, 0);
        chk(byte_cnt == 0 && csr_rdata[0] == 0, "R1 short setup not loaded", byte_cnt, 0);
    endtask

    task automatic t_corrupt();
        token(2); bytes(8, 0); eop(0, 1);
        chk(!c_hsv && !c_irq && byte_cnt == 0, "R2 corrupt setup", byte_cnt, 0);
        setup_ok(0, "R2");
        token(0); bytes(4, 5); eop(0, 1);
        chk(!c_hsv && !c_irq, "R2 corrupt OUT silent", c_irq, 0);
        chk(byte_cnt == 0 && csr_rdata[0] == 0, "R2 corrupt OUT not loaded", byte_cnt, 0);
    endtask

    task automatic t_out_xfer();
        setup_ok(0, "R3");
        token(0); bytes(5, 8'h40); eop(1, 0);
        chk(c_hsv && c_hs == 0 && c_irq, "R3 OUT ACK", c_hs, 0);
        chk(byte_cnt == 5 && csr_rdata[0], "R3 OUT loaded", byte_cnt, 5);
        token(0); bytes(3, 8'h60); eop(0, 0);
        chk(c_hsv && c_hs == 1, "R3 NAK when busy", c_hs, 1);
        chk(byte_cnt == 5, "R3 count kept", byte_cnt, 5);
        csr(9);
        chk(csr_rdata[3] && !csr_rdata[0], "R5 data-end set", csr_rdata, 8);
        token(1);
        chk(c_tx && c_len == 0, "R5 zero-length status send", c_len, 0);
        hack();
        chk(c_irq && csr_rdata[3] == 0, "R5 status done", csr_rdata[3], 0);
    endtask

    task automatic t_out_after_end();
        setup_ok(0, "R6");
        csr(8);
        token(0);
        chk(c_hsv && c_hs == 2 && c_irq, "R6 OUT after data-end stall", c_hs, 2);
        chk(csr_rdata[2] == 1, "R11 sent-stall set", csr_rdata[2], 1);
        csr(4);
        chk(csr_rdata[2] == 0, "R11 sent-stall cleared", csr_rdata[2], 0);
    endtask

    task automatic t_oversize();
        setup_ok(0, "R8");
        token(0); bytes(MAX_PKT + 1, 0); eop(0, 0);
        chk(c_hsv && c_hs == 2 && c_irq, "R8 oversize stall", c_hs, 2);
        chk(byte_cnt == 0, "R8 nothing kept", byte_cnt, 0);
        csr(4);
    endtask

    task automatic t_in_xfer();
        setup_ok(1, "R4");
        push_fw(8'hA0); push_fw(8'hA1); push_fw(8'hA2);
        csr(10);
        token(1);
        chk(c_tx && c_len == 3 && !c_hsv, "R4 tx start len", c_len, 3);
        chk(fifo_rdata == 8'hA0, "R4 tx head", fifo_rdata, 8'hA0);
        @(negedge clk); tx_rd = 1; @(negedge clk); tx_rd = 0;
        chk(fifo_rdata == 8'hA1, "R4 tx pop", fifo_rdata, 8'hA1);
        hack();
        chk(c_irq && csr_rdata[1] == 0 && byte_cnt == 0, "R4 ack clears in-ready", csr_rdata[1], 0);
        token(0); eop(1, 0);
        chk(c_hsv && c_hs == 0 && c_irq, "R5 status OUT ACK", c_hs, 0);
        chk(csr_rdata[3] == 0, "R5 data-end cleared", csr_rdata[3], 0);
    endtask

    task automatic t_in_after_end();
        setup_ok(1, "R7");
        csr(10);
        token(1);
        chk(c_tx && c_len == 0, "R7 last empty packet", c_len, 0);
        hack();
        token(1);
        chk(c_hsv && c_hs == 2 && csr_rdata[2], "R7 IN after data-end stall", c_hs, 2);
        csr(4);
    endtask

    task automatic t_status_data1();
        setup_ok(1, "R9");
        csr(8);
        token(0); bytes(2, 0); eop(1, 0);
        chk(c_hsv && c_hs == 2 && c_irq, "R9 nonzero DATA1 stall", c_hs, 2);
        csr(4);
    endtask

    task automatic t_early_end();
        setup_ok(1, "R12");
        token(0);
        chk(c_irq && csr_rdata[4], "R12 setup-end set", csr_rdata[4], 1);
        chk(c_hsv && c_hs == 1, "R12 NAK", c_hs, 1);
        csr(16);
        chk(csr_rdata[4] == 0, "R12 setup-end cleared", csr_rdata[4], 0);
    endtask

    task automatic t_force();
        setup_ok(0, "R10");
        csr(32);
        chk(csr_rdata[5] == 1, "R10 send-stall pending", csr_rdata[5], 1);
        token(1);
        chk(c_hsv && c_hs == 2 && c_irq, "R10 forced stall", c_hs, 2);
        chk(csr_rdata[5] == 0 && csr_rdata[2], "R10 pending cleared", csr_rdata, 4);
        @(negedge clk);
        chk(!irq, "R13 irq one cycle", irq, 0);
        chk(irq_pend, "R13 pending sticky", irq_pend, 1);
        @(negedge clk); irq_rd = 1; @(negedge clk); irq_rd = 0;
        chk(!irq_pend, "R13 pending cleared by read", irq_pend, 1'b0);
        csr(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_setup();
        t_corrupt();
        t_out_xfer();
        t_out_after_end();
        t_oversize();
        t_in_xfer();
        t_in_after_end();
        t_status_data1();
        t_early_end();
        t_force();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule